// File: doc/BRIEF.md
# Selectable Arithmetic and Shift Unit

This unit is the arithmetic and shift datapath of a small register machine with a W-bit word (8 by default). It takes two operands, `a` and `b`. It returns either the output of a single ripple adder or a one-position shifted copy of `a`. The adder covers four operations by changing what it sees as its second input. A steering bit and the carry-in pick one of four words: `b`, zero, all ones, or the complement of `b`. The four operations are add, increment, decrement and subtract.

The shift side supports arithmetic, logical and circular moves, both left and right. The bit that leaves the word appears on its own output, so a neighbouring stage can chain it in as a serial input or carry. Overflow is reported in two cases: a signed add or subtract overflows, or an arithmetic left shift changes the sign bit. The result and all flags are captured in one output register stage, so they appear one clock after the inputs.

Top module: `asu_unit`

## Requirements
- R1: While `rst_n` is low, `res_q`, `cout_q`, `ovf_q` and `sout_q` are all zero.
- R2: The adder is selected by `op` code 0 or 7. In that mode, with `steer`=0 and `cin`=0, `res_q` is a+b mod 2^W and `cout_q` is the carry out of the top bit.
- R3: In adder mode with `steer`=0 and `cin`=1, `res_q` is a+1 and `cout_q` is set only when `a` is all ones.
- R4: In adder mode with `steer`=1 and `cin`=0, `res_q` is a−1, computed as a plus all ones. `cout_q` is set for every `a` except zero.
- R5: In adder mode with `steer`=1 and `cin`=1, `res_q` is a−b in two's complement. `cout_q` is 1 exactly when a ≥ b unsigned, meaning no borrow.
- R6: In adder mode, `ovf_q` is the exclusive-or of the carry into the top bit and the carry out of it. It is set exactly when the signed result has a sign that the operands cannot produce.
- R7: `op`=1 is the arithmetic right shift. The top bit of `a` is kept and copied down, so 10011100 gives 11001110.
- R8: `op`=2 is the arithmetic left shift. It puts 0 in bit 0 and sets `ovf_q` when the old top bit differs from the new top bit. For example, 10011100 gives 00111000 with `ovf_q`=1.
- R9: `op`=3 is the logical right shift and `op`=4 is the logical left shift. Each fills the vacated end with 0.
- R10: `op`=5 rotates right and `op`=6 rotates left. The bit leaving one end re-enters at the other end, so 11011101 rotated right gives 11101110.
- R11: For every shift code, `sout_q` is the bit that left the word: `a[0]` for right moves and `a[W-1]` for left moves. In adder mode `sout_q` is 0.
- R12: For every shift code `cout_q` is 0. For logical shifts and rotates `ovf_q` is also 0.
- R13: Outputs follow the inputs sampled at the previous rising edge of `clk`, with exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Operation: 0/7 adder, 1 asr, 2 asl, 3 lsr, 4 lsl, 5 ror, 6 rol |
| steer | input | 1 | Adder second-input select bit |
| cin | input | 1 | Adder carry-in, also part of the operand steering |
| a | input | W | First operand and the shift source |
| b | input | W | Second operand |
| res_q | output | W | Registered result |
| cout_q | output | 1 | Registered adder carry-out |
| ovf_q | output | 1 | Registered overflow flag |
| sout_q | output | 1 | Registered shifted-out bit |

## Verification
The operand set mixes zero, all ones, the two sign boundaries 0x7F and 0x80, and irregular words. Zero and all ones separate the carry behaviour of increment and decrement. The sign boundaries separate a correct overflow rule from a plain carry test. Pairing each `a` with several `b` values under every steer/carry-in combination shows whether the operand steering chooses the right word. Codes 0 and 7 must give identical results. For the shifts, asymmetric patterns such as 0x9C, 0xDD and 0xA3 show which end gets filled and with what value, and whether `sout_q` comes from the correct end.

// File: rtl/asu_pkg.sv
package asu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ASR = 3'd1,
        OP_ASL = 3'd2,
        OP_LSR = 3'd3,
        OP_LSL = 3'd4,
        OP_ROR = 3'd5,
        OP_ROL = 3'd6,
        OP_AD2 = 3'd7
    } asu_op_e;

    localparam int OP_W = 3;

endpackage

// File: rtl/asu_operand_steer.sv
module asu_operand_steer #(
    parameter int W = 8
) (
    input  logic         steer,
    input  logic         cin,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    // Four second-operand choices feed one adder.
    always_comb begin
        unique case ({steer, cin})
            2'b00:   y = b;
            2'b01:   y = '0;
            2'b10:   y = '1;
            default: y = ~b;
        endcase
    end
endmodule

// File: rtl/asu_ripple_adder.sv
module asu_ripple_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_top_in,
    output logic         cout
);
    logic [W:0] c;

    assign c[0] = cin;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_fa
            assign sum[i]  = a[i] ^ y[i] ^ c[i];
            assign c[i+1]  = (a[i] & y[i]) | (c[i] & (a[i] ^ y[i]));
        end
    endgenerate

    assign c_top_in = c[W-1];
    assign cout     = c[W];
endmodule

// File: rtl/asu_shifter.sv
module asu_shifter
    import asu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    output logic [W-1:0]    res,
    output logic            sout,
    output logic            ovf
);
    logic         go_right;
    logic         fill_r;
    logic         fill_l;
    logic [W-1:0] rmov;
    logic [W-1:0] lmov;

    always_comb begin
        go_right = (op == OP_ASR) || (op == OP_LSR) || (op == OP_ROR);
        fill_r   = 1'b0;
        fill_l   = 1'b0;
        if (op == OP_ASR) fill_r = a[W-1];
        if (op == OP_ROR) fill_r = a[0];
        if (op == OP_ROL) fill_l = a[W-1];
    end

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            if (i == W-1) begin : g_rtop
                assign rmov[i] = fill_r;
            end else begin : g_rmid
                assign rmov[i] = a[i+1];
            end
            if (i == 0) begin : g_lbot
                assign lmov[i] = fill_l;
            end else begin : g_lmid
                assign lmov[i] = a[i-1];
            end
        end
    endgenerate

    always_comb begin
        res  = go_right ? rmov : lmov;
        sout = go_right ? a[0] : a[W-1];
        ovf  = (op == OP_ASL) && (a[W-1] != a[W-2]);
    end
endmodule

// File: rtl/asu_unit.sv
module asu_unit
    import asu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op,
    input  logic            steer,
    input  logic            cin,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    res_q,
    output logic            cout_q,
    output logic            ovf_q,
    output logic            sout_q
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         cout;
        logic         ovf;
        logic         sout;
    } asu_out_t;

    asu_out_t     out_d;
    asu_out_t     out_q;
    logic [W-1:0] y_op;
    logic [W-1:0] sum;
    logic         c_top_in;
    logic         add_cout;
    logic [W-1:0] sh_res;
    logic         sh_sout;
    logic         sh_ovf;
    logic         is_add;

    asu_operand_steer #(.W(W)) u_steer (
        .steer (steer),
        .cin   (cin),
        .b     (b),
        .y     (y_op)
    );

    asu_ripple_adder #(.W(W)) u_add (
        .a        (a),
        .y        (y_op),
        .cin      (cin),
        .sum      (sum),
        .c_top_in (c_top_in),
        .cout     (add_cout)
    );

    asu_shifter #(.W(W)) u_shift (
        .op   (op),
        .a    (a),
        .res  (sh_res),
        .sout (sh_sout),
        .ovf  (sh_ovf)
    );

    always_comb begin
        is_add = (op == OP_ADD) || (op == OP_AD2);
        out_d  = '0;
        if (is_add) begin
            out_d.res  = sum;
            out_d.cout = add_cout;
            out_d.ovf  = c_top_in ^ add_cout;
        end else begin
            out_d.res  = sh_res;
            out_d.sout = sh_sout;
            out_d.ovf  = sh_ovf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_q  = out_q.res;
    assign cout_q = out_q.cout;
    assign ovf_q  = out_q.ovf;
    assign sout_q = out_q.sout;
endmodule

// File: rtl/asu_unit_chk.sv
module asu_unit_chk
    import asu_pkg::*;
#(
    parameter int W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [OP_W-1:0] op,
    input logic [W-1:0]    a,
    input logic [W-1:0]    res_q,
    input logic            cout_q,
    input logic            ovf_q,
    input logic            sout_q
);
    logic is_shift;
    logic is_plain;
    assign is_shift = (op != OP_ADD) && (op != OP_AD2);
    assign is_plain = (op == OP_LSR) || (op == OP_LSL) || (op == OP_ROR) || (op == OP_ROL);

    // R12
    shift_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_shift |=> !cout_q);

    // R11
    add_no_sout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_shift |=> !sout_q);

    // R12
    plain_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_plain |=> !ovf_q);

    // R7
    asr_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ASR) |=> (res_q[W-1] == $past(a[W-1])) && (sout_q == $past(a[0])));

    // R10
    ror_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ROR) |=> (res_q[W-1] == $past(a[0])) && (res_q[0] == $past(a[1])));

    // R8
    asl_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ASL) |=> (ovf_q == ($past(a[W-1]) != res_q[W-1])) && !res_q[0]);
endmodule

bind asu_unit asu_unit_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .a      (a),
    .res_q  (res_q),
    .cout_q (cout_q),
    .ovf_q  (ovf_q),
    .sout_q (sout_q)
);

// File: tb/tb_asu_unit.sv
`timescale 1ns/1ps
module tb_asu_unit;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op = 3'd0;
    logic         steer = 1'b0;
    logic         cin = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [W-1:0] res_q;
    logic         cout_q, ovf_q, sout_q;

    int errs = 0;
    int checks = 0;
    int cyc = 0;

    typedef struct {
        int           tag;
        string        req;
        logic [W-1:0] res;
        logic         cout;
        logic         ovf;
        logic         sout;
    } exp_t;

    exp_t sb[$];

    asu_unit #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .op(op), .steer(steer), .cin(cin),
        .a(a), .b(b), .res_q(res_q), .cout_q(cout_q), .ovf_q(ovf_q), .sout_q(sout_q)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic exp_t model(input logic [2:0] o, input logic s, input logic c,
                                   input logic [W-1:0] x, input logic [W-1:0] z);
        exp_t e;
        logic [W-1:0] y;
        logic [W:0]   full;
        e.tag = 0; e.req = ""; e.res = '0; e.cout = 0; e.ovf = 0; e.sout = 0;
        case (o)
            3'd0, 3'd7: begin
                if (!s) y = c ? '0 : z;
                else    y = c ? ~z : '1;
                full   = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
                e.res  = full[W-1:0];
                e.cout = full[W];
                e.ovf  = (x[W-1] == y[W-1]) && (full[W-1] != x[W-1]);
                e.req  = !s ? (c ? "R3 R6" : "R2 R6") : (c ? "R5 R6" : "R4 R6");
            end
            3'd1: begin e.res = {x[W-1], x[W-1:1]}; e.sout = x[0];   e.req = "R7 R11"; end
            3'd2: begin e.res = {x[W-2:0], 1'b0};   e.sout = x[W-1];
                        e.ovf = x[W-1] ^ x[W-2];       e.req = "R8 R11"; end
            3'd3: begin e.res = {1'b0, x[W-1:1]};   e.sout = x[0];   e.req = "R9 R11 R12"; end
            3'd4: begin e.res = {x[W-2:0], 1'b0};   e.sout = x[W-1]; e.req = "R9 R11 R12"; end
            3'd5: begin e.res = {x[0], x[W-1:1]};   e.sout = x[0];   e.req = "R10 R11 R12"; end
            default: begin e.res = {x[W-2:0], x[W-1]}; e.sout = x[W-1]; e.req = "R10 R11 R12"; end
        endcase
        return e;
    endfunction

    task automatic drive(input logic [2:0] o, input logic s, input logic c,
                         input logic [W-1:0] x, input logic [W-1:0] z);
        exp_t e;
        @(negedge clk);
        op = o; steer = s; cin = c; a = x; b = z;
        e = model(o, s, c, x, z);
        e.tag = cyc;
        sb.push_back(e);
    endtask

    // Monitor: results are due one rising edge after issue (R13)
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0 && sb[0].tag < cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (res_q !== e.res || cout_q !== e.cout || ovf_q !== e.ovf || sout_q !== e.sout) begin
                errs++;
                $display("FAIL %s R13: actual res=%h cout=%b ovf=%b sout=%b expected res=%h cout=%b ovf=%b sout=%b",
                         e.req, res_q, cout_q, ovf_q, sout_q, e.res, e.cout, e.ovf, e.sout);
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        errs++; checks++;
        $display("FAIL watchdog R13: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] av [8];
        logic [W-1:0] bv [4];
        av = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h9C, 8'hDD, 8'h55, 8'hA3};
        bv = '{8'h01, 8'hFF, 8'h80, 8'h3C};

        // R1: reset state, with inputs that would otherwise produce nonzero outputs
        op = 3'd2; a = 8'h9C;
        repeat (3) @(negedge clk);
        checks++;
        if (res_q !== '0 || cout_q !== 0 || ovf_q !== 0 || sout_q !== 0) begin
            errs++;
            $display("FAIL R1: actual res=%h cout=%b ovf=%b sout=%b expected all zero",
                     res_q, cout_q, ovf_q, sout_q);
        end
        @(negedge clk); rst_n = 1'b1;

        // Worked examples: R7 asr, R8 asl overflow, R10 rotate right
        drive(3'd1, 0, 0, 8'h9C, 8'h00);
        drive(3'd2, 0, 0, 8'h9C, 8'h00);
        drive(3'd5, 0, 0, 8'hDD, 8'h00);
        // R6 boundaries: 7F+1 and 80-1 overflow; R3 FF+1 carry; R4 00-1 no carry
        drive(3'd0, 0, 0, 8'h7F, 8'h01);
        drive(3'd0, 1, 1, 8'h80, 8'h01);
        drive(3'd0, 0, 1, 8'hFF, 8'h00);
        drive(3'd0, 1, 0, 8'h00, 8'h00);
        // R5 equal operands: result zero, no borrow
        drive(3'd7, 1, 1, 8'h5A, 8'h5A);

        // Sweep: adder codes 0 and 7 under every steer/carry-in, R2 R3 R4 R5 R6
        for (int o = 0; o < 8; o++) begin
            for (int i = 0; i < 8; i++) begin
                if (o == 0 || o == 7) begin
                    for (int j = 0; j < 4; j++)
                        for (int k = 0; k < 4; k++)
                            drive(3'(o), k[1], k[0], av[i], bv[j]);
                end else begin
                    drive(3'(o), i[0], i[1], av[i], bv[i % 4]);
                end
            end
        end

        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            errs++; checks++;
            $display("FAIL R13: actual pending=%0d expected pending=0", sb.size());
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule